// File: doc/BRIEF.md
# Interleaved Hardware Thread Scheduler

This block sequences instruction fetch for a barrel-style core. It keeps one program counter per hardware thread and offers the fetch stage one thread per cycle, visiting the threads in a fixed rotation. A thread is revisited only after every other thread has had its slot. Because of that, a branch or jump target sent back from execute reaches the thread's program counter before that thread fetches again. No flush and no dependency stall are ever needed.

The fetch request leaves the block as a valid/ready stream. `fetch_valid` rises on the first clock edge after reset and then stays high. The offered thread ID and PC stay put while `fetch_ready` is low. The slot advances only on a cycle where both valid and ready are high. Redirects are always accepted and have no ready signal. Each thread also has a software-interrupt pending bit. Any thread can raise the bit of another thread with a set request. The target thread clears its own bit with an acknowledge.

The thread count is the parameter `THREADS`. It defaults to three, and any value below three is rejected at elaboration. Each thread's boot address is `BOOT_BASE + i*BOOT_STRIDE`.

Top module: `ths_scheduler`

## Requirements
- R1: While `rst_n` is low, `fetch_valid` is 0 and `swi_pending` is all zeros. On the first cycle after reset in which `fetch_valid` is 1, the block offers thread 0 at `BOOT_BASE`. Thread i first fetches at `BOOT_BASE + i*BOOT_STRIDE`. Once `fetch_valid` is 1, it stays 1 until the next reset.
- R2: Each accepted fetch (`fetch_valid` and `fetch_ready` both 1) moves `fetch_tid` to the next thread in the following cycle. The order is 0, 1, …, THREADS-1 and then back to 0.
- R3: While `fetch_valid` is 1 and `fetch_ready` is 0, `fetch_tid` holds its value. `fetch_pc` also holds, unless a redirect names the offered thread.
- R4: When a thread's fetch is accepted and no redirect names that thread in the same cycle, the thread's PC increases by 4.
- R5: A redirect (`redir_valid` = 1) writes `redir_target` into the PC of thread `redir_tid` only. This also applies during a stall. The new value is what that thread fetches at its next slot.
- R6: If a redirect names the thread whose fetch is accepted in the same cycle, the PC takes the redirect target and not the old PC plus 4.
- R7: A thread ID of THREADS or above has no effect on any PC or pending bit. This applies to redirects, interrupt sets and acknowledges alike.
- R8: A set request (`swi_set_valid` = 1) makes bit `swi_set_tid` of `swi_pending` 1 in the next cycle. The other bits are unchanged.
- R9: An acknowledge (`swi_ack_valid` = 1) clears bit `swi_ack_tid` in the next cycle. If a set and an acknowledge name the same thread in the same cycle, the bit ends up 1. Acknowledging a bit that is already clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | output | 1 | A fetch slot is offered |
| fetch_ready | input | 1 | Fetch stage takes the offered slot |
| fetch_tid | output | $clog2(THREADS) | Thread owning the offered slot |
| fetch_pc | output | PC_W | Address to fetch for that thread |
| redir_valid | input | 1 | Execute sends a new PC |
| redir_tid | input | $clog2(THREADS) | Thread the new PC belongs to |
| redir_target | input | PC_W | Branch or jump target |
| swi_set_valid | input | 1 | Raise a software interrupt |
| swi_set_tid | input | $clog2(THREADS) | Thread to interrupt |
| swi_ack_valid | input | 1 | Acknowledge a software interrupt |
| swi_ack_tid | input | $clog2(THREADS) | Thread acknowledging its interrupt |
| swi_pending | output | THREADS | Pending software interrupt, one bit per thread |

## Verification
The bench builds the block with the minimum of three threads, `BOOT_BASE` = 0x1000 and `BOOT_STRIDE` = 0x100, so every thread boots at a distinct, recognisable address. Three threads in a 2-bit thread ID leave the code 3 unused. That code is what makes the out-of-range redirect, set and acknowledge cases reachable at the ports. The short rotation also lets the wrap from thread 2 to thread 0 come up many times within a few cycles. It allows stalls and redirects that land on the same cycle as the slot to be lined up by hand.

// File: rtl/ths_pkg.sv
package ths_pkg;
  localparam int unsigned THS_MIN_THREADS = 3;
  localparam int unsigned THS_INSTR_BYTES = 4;
endpackage

// File: rtl/ths_slot_rotor.sv
module ths_slot_rotor #(
  parameter int unsigned THREADS = 3,
  parameter int unsigned TID_W   = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [TID_W-1:0] slot
);
  localparam logic [TID_W-1:0] LAST = TID_W'(THREADS - 1);

  logic [TID_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (advance) begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  assign slot = slot_q;
endmodule

// File: rtl/ths_pc_bank.sv
module ths_pc_bank #(
  parameter int unsigned       THREADS     = 3,
  parameter int unsigned       TID_W       = $clog2(THREADS),
  parameter int unsigned       PC_W        = 32,
  parameter logic [PC_W-1:0]   BOOT_BASE   = '0,
  parameter logic [PC_W-1:0]   BOOT_STRIDE = PC_W'(256)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [TID_W-1:0] step_tid,
  input  logic             redir_valid,
  input  logic [TID_W-1:0] redir_tid,
  input  logic [PC_W-1:0]  redir_target,
  input  logic [TID_W-1:0] read_tid,
  output logic [PC_W-1:0]  read_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(ths_pkg::THS_INSTR_BYTES);

  logic [PC_W-1:0] pc_q [THREADS];

  for (genvar i = 0; i < THREADS; i++) begin : g_thr
    localparam logic [PC_W-1:0] BOOT_I = BOOT_BASE + PC_W'(i) * BOOT_STRIDE;
    logic hit_redir;
    logic hit_step;

    assign hit_redir = redir_valid && (redir_tid == TID_W'(i));
    assign hit_step  = step_en && (step_tid == TID_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[i] <= BOOT_I;
      end else if (hit_redir) begin
        pc_q[i] <= redir_target;
      end else if (hit_step) begin
        pc_q[i] <= pc_q[i] + STEP;
      end
    end
  end

  assign read_pc = pc_q[read_tid];
endmodule

// File: rtl/ths_swi_bank.sv
module ths_swi_bank #(
  parameter int unsigned THREADS = 3,
  parameter int unsigned TID_W   = $clog2(THREADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_valid,
  input  logic [TID_W-1:0]   set_tid,
  input  logic               ack_valid,
  input  logic [TID_W-1:0]   ack_tid,
  output logic [THREADS-1:0] pending
);
  logic [THREADS-1:0] pend_q;

  for (genvar i = 0; i < THREADS; i++) begin : g_bit
    logic raise;
    logic lower;

    assign raise = set_valid && (set_tid == TID_W'(i));
    assign lower = ack_valid && (ack_tid == TID_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
      end else if (raise) begin
        pend_q[i] <= 1'b1;
      end else if (lower) begin
        pend_q[i] <= 1'b0;
      end
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/ths_scheduler.sv
module ths_scheduler #(
  parameter int unsigned     THREADS     = 3,
  parameter int unsigned     PC_W        = 32,
  parameter logic [PC_W-1:0] BOOT_BASE   = '0,
  parameter logic [PC_W-1:0] BOOT_STRIDE = PC_W'(256)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic                       fetch_valid,
  input  logic                       fetch_ready,
  output logic [$clog2(THREADS)-1:0] fetch_tid,
  output logic [PC_W-1:0]            fetch_pc,
  input  logic                       redir_valid,
  input  logic [$clog2(THREADS)-1:0] redir_tid,
  input  logic [PC_W-1:0]            redir_target,
  input  logic                       swi_set_valid,
  input  logic [$clog2(THREADS)-1:0] swi_set_tid,
  input  logic                       swi_ack_valid,
  input  logic [$clog2(THREADS)-1:0] swi_ack_tid,
  output logic [THREADS-1:0]         swi_pending
);
  localparam int unsigned TID_W = $clog2(THREADS);

  if (THREADS < ths_pkg::THS_MIN_THREADS) begin : g_too_few
    $error("ths_scheduler: THREADS must be at least 3");
  end

  logic run_q;
  logic take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign fetch_valid = run_q;
  assign take        = run_q && fetch_ready;

  ths_slot_rotor #(.THREADS(THREADS), .TID_W(TID_W)) u_rotor (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (take),
    .slot    (fetch_tid)
  );

  ths_pc_bank #(
    .THREADS     (THREADS),
    .TID_W       (TID_W),
    .PC_W        (PC_W),
    .BOOT_BASE   (BOOT_BASE),
    .BOOT_STRIDE (BOOT_STRIDE)
  ) u_pcs (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en      (take),
    .step_tid     (fetch_tid),
    .redir_valid  (redir_valid),
    .redir_tid    (redir_tid),
    .redir_target (redir_target),
    .read_tid     (fetch_tid),
    .read_pc      (fetch_pc)
  );

  ths_swi_bank #(.THREADS(THREADS), .TID_W(TID_W)) u_swi (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (swi_set_valid),
    .set_tid   (swi_set_tid),
    .ack_valid (swi_ack_valid),
    .ack_tid   (swi_ack_tid),
    .pending   (swi_pending)
  );
endmodule

// File: rtl/ths_scheduler_chk.sv
module ths_scheduler_chk #(
  parameter int unsigned THREADS = 3,
  parameter int unsigned TID_W   = $clog2(THREADS),
  parameter int unsigned PC_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_valid,
  input logic               fetch_ready,
  input logic [TID_W-1:0]   fetch_tid,
  input logic [PC_W-1:0]    fetch_pc,
  input logic               redir_valid,
  input logic [TID_W-1:0]   redir_tid,
  input logic               swi_set_valid,
  input logic [TID_W-1:0]   swi_set_tid,
  input logic               swi_ack_valid,
  input logic [TID_W-1:0]   swi_ack_tid,
  input logic [THREADS-1:0] swi_pending
);
  localparam logic [TID_W:0]   LIMIT = (TID_W+1)'(THREADS);
  localparam logic [TID_W-1:0] LAST  = TID_W'(THREADS - 1);

  // R1
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> fetch_valid);

  // R2
  slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=>
      (fetch_tid == (($past(fetch_tid) == LAST) ? '0 : $past(fetch_tid) + 1'b1)));

  // R3
  stall_tid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> $stable(fetch_tid));

  // R3
  stall_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !(redir_valid && redir_tid == fetch_tid))
      |=> $stable(fetch_pc));

  // R8
  swi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_set_valid && ({1'b0, swi_set_tid} < LIMIT))
      |=> swi_pending[$past(swi_set_tid)]);

  // R9
  swi_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_ack_valid && ({1'b0, swi_ack_tid} < LIMIT)
       && !(swi_set_valid && swi_set_tid == swi_ack_tid))
      |=> !swi_pending[$past(swi_ack_tid)]);
endmodule

bind ths_scheduler ths_scheduler_chk #(
  .THREADS (THREADS),
  .TID_W   (TID_W),
  .PC_W    (PC_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_valid   (fetch_valid),
  .fetch_ready   (fetch_ready),
  .fetch_tid     (fetch_tid),
  .fetch_pc      (fetch_pc),
  .redir_valid   (redir_valid),
  .redir_tid     (redir_tid),
  .swi_set_valid (swi_set_valid),
  .swi_set_tid   (swi_set_tid),
  .swi_ack_valid (swi_ack_valid),
  .swi_ack_tid   (swi_ack_tid),
  .swi_pending   (swi_pending)
);

// File: tb/sim_ths_scheduler.sv
module sim_ths_scheduler;
  localparam int unsigned NT = 3;
  localparam int unsigned TW = 2;
  localparam int unsigned PW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid;
  logic          fetch_ready = 1'b0;
  logic [TW-1:0] fetch_tid;
  logic [PW-1:0] fetch_pc;
  logic          redir_valid = 1'b0;
  logic [TW-1:0] redir_tid = '0;
  logic [PW-1:0] redir_target = '0;
  logic          swi_set_valid = 1'b0;
  logic [TW-1:0] swi_set_tid = '0;
  logic          swi_ack_valid = 1'b0;
  logic [TW-1:0] swi_ack_tid = '0;
  logic [NT-1:0] swi_pending;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ths_scheduler #(
    .THREADS(NT), .PC_W(PW), .BOOT_BASE(32'h1000), .BOOT_STRIDE(32'h100)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_tid(fetch_tid), .fetch_pc(fetch_pc),
    .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_target(redir_target),
    .swi_set_valid(swi_set_valid), .swi_set_tid(swi_set_tid),
    .swi_ack_valid(swi_ack_valid), .swi_ack_tid(swi_ack_tid),
    .swi_pending(swi_pending)
  );

  typedef struct packed {
    logic          rdy;
    logic          rv;
    logic [1:0]    rtid;
    logic [31:0]   rtgt;
    logic [1:0]    etid;
    logic [31:0]   epc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd0, 32'h0,    2'd0, 32'h1000},
    '{1'b1, 1'b0, 2'd0, 32'h0,    2'd1, 32'h1100},
    '{1'b1, 1'b1, 2'd0, 32'h2000, 2'd2, 32'h1200},
    '{1'b1, 1'b0, 2'd0, 32'h0,    2'd0, 32'h2000},
    '{1'b0, 1'b0, 2'd0, 32'h0,    2'd1, 32'h1104},
    '{1'b0, 1'b1, 2'd1, 32'h3000, 2'd1, 32'h1104},
    '{1'b1, 1'b0, 2'd0, 32'h0,    2'd1, 32'h3000},
    '{1'b1, 1'b1, 2'd2, 32'h4000, 2'd2, 32'h1204},
    '{1'b1, 1'b0, 2'd0, 32'h0,    2'd0, 32'h2004},
    '{1'b1, 1'b0, 2'd0, 32'h0,    2'd1, 32'h3004},
    '{1'b1, 1'b0, 2'd0, 32'h0,    2'd2, 32'h4000},
    '{1'b1, 1'b0, 2'd0, 32'h0,    2'd0, 32'h2008}
  };
  localparam string TAGS [NV] = '{
    "R1", "R2", "R5", "R4", "R3", "R3", "R5", "R6", "R4", "R2", "R6", "R2"
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    redir_valid = 1'b0;
    swi_set_valid = 1'b0;
    swi_ack_valid = 1'b0;
  endtask

  task automatic swi_step(input logic sv, input logic [1:0] st,
                          input logic av, input logic [1:0] at,
                          input string tag, input logic [2:0] exp);
    swi_set_valid = sv; swi_set_tid = st;
    swi_ack_valid = av; swi_ack_tid = at;
    @(negedge clk);
    idle_inputs();
    chk(tag, 64'(swi_pending), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", 64'(fetch_valid), 64'd0);
    chk("R1 pending in reset", 64'(swi_pending), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      fetch_ready  = VECS[k].rdy;
      redir_valid  = VECS[k].rv;
      redir_tid    = VECS[k].rtid;
      redir_target = VECS[k].rtgt;
      chk({TAGS[k], " valid"}, 64'(fetch_valid), 64'd1);
      chk({TAGS[k], " tid"}, 64'(fetch_tid), 64'(VECS[k].etid));
      chk({TAGS[k], " pc"}, 64'(fetch_pc), 64'(VECS[k].epc));
      @(negedge clk);
    end
    idle_inputs();
    fetch_ready = 1'b0;

    // R7: redirect naming thread 3 touches no PC (state: slot 1, pcs 200C/3008/4004)
    redir_valid = 1'b1; redir_tid = 2'd3; redir_target = 32'hDEAD0000;
    @(negedge clk);
    idle_inputs();
    fetch_ready = 1'b1;
    chk("R7 tid1", 64'(fetch_tid), 64'd1);
    chk("R7 pc1", 64'(fetch_pc), 64'h3008);
    @(negedge clk);
    chk("R7 pc2", 64'(fetch_pc), 64'h4004);
    @(negedge clk);
    chk("R7 pc0", 64'(fetch_pc), 64'h200C);
    @(negedge clk);
    fetch_ready = 1'b0;
    chk("R4 wrap pc1", 64'(fetch_pc), 64'h300C);

    // R8 / R9 / R7: software interrupts
    swi_step(1'b1, 2'd2, 1'b0, 2'd0, "R8 set t2", 3'b100);
    swi_step(1'b1, 2'd0, 1'b1, 2'd2, "R9 ack t2 set t0", 3'b001);
    swi_step(1'b1, 2'd0, 1'b1, 2'd0, "R9 set wins", 3'b001);
    swi_step(1'b0, 2'd0, 1'b1, 2'd1, "R9 ack clear bit", 3'b001);
    swi_step(1'b1, 2'd3, 1'b0, 2'd0, "R7 set t3", 3'b001);
    swi_step(1'b0, 2'd0, 1'b1, 2'd3, "R7 ack t3", 3'b001);
    swi_step(1'b0, 2'd0, 1'b1, 2'd0, "R9 ack t0", 3'b000);
    swi_step(1'b1, 2'd1, 1'b0, 2'd0, "R8 set t1", 3'b010);

    // R1: reset in mid-run restores boot state
    rst_n = 1'b0;
    #1;
    chk("R1 valid re-reset", 64'(fetch_valid), 64'd0);
    chk("R1 pending re-reset", 64'(swi_pending), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fetch_ready = 1'b1;
    chk("R1 boot tid0", 64'(fetch_tid), 64'd0);
    chk("R1 boot pc0", 64'(fetch_pc), 64'h1000);
    @(negedge clk);
    chk("R1 boot pc1", 64'(fetch_pc), 64'h1100);
    @(negedge clk);
    chk("R1 boot pc2", 64'(fetch_pc), 64'h1200);
    @(negedge clk);
    chk("R2 wrap tid", 64'(fetch_tid), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule